// File: doc/BRIEF.md
# Segment Protection Limit Checker

This block decides whether one memory access is legal within a segment in a segmented addressing scheme. It takes the access address and byte count, the read, write and execute intent, the segment base, limit and attribute bits, and the processor mode bits. It raises a general-protection fault when the access breaks the segment's attribute rules or falls outside the segment's valid range. The address arriving here already has the segment base added. Adding the base, loading descriptors, privilege checks and paging are handled by other blocks.

Segments come in two kinds. An expand-up segment accepts addresses up to the limit. An expand-down segment accepts addresses above the limit. Either kind may have a limit that is numerically below its base, which is a range that wraps around the address space. Each of the four combinations uses its own fault inequality. No check is made in real mode, or when both the long-mode-active bit and the code-segment long-mode bit are set. The result can be registered for one cycle or passed out combinationally, which is chosen by a parameter. Inside the block, each access is first sorted into one of five check paths: `P_OFF`, `P_UP_FLAT`, `P_UP_WRAP`, `P_DN_FLAT` and `P_DN_WRAP`. The fault logic then branches on the path. The output register has two states: reset (no result) and valid (holds the last result).

Top module: `seg_prot_checker`

## Requirements
- R1: When `prot_en` is 0, `gp_fault` is 0 whatever the other inputs are.
- R2: When `prot_en`, `lma` and `cs_long` are all 1, no check is made and `gp_fault` is 0. If only one of `lma` and `cs_long` is 1, the checks are made.
- R3: When checks are made, a write (`acc_wr`=1) to a segment with `seg_wr`=0 faults. A write to a segment with `seg_wr`=1 does not fault because of its attributes.
- R4: When checks are made, a read (`acc_wr`=0 and `acc_ex`=0) from a segment with `seg_rd`=0 faults. An execute access (`acc_ex`=1) is not blocked by `seg_rd`=0.
- R5: Expand-up segment (`seg_down`=0) with limit >= base: the access faults when limit < address + size.
- R6: Expand-up segment with limit < base: the access faults when limit < address + size and address < base.
- R7: Expand-down segment (`seg_down`=1) with limit < base: the access faults when address <= limit or address + size >= base.
- R8: Expand-down segment with limit >= base: the access faults when address <= limit and address + size >= base.
- R9: Address + size is computed with one extra bit, so an access that ends past the top of the address space compares as larger than any limit.
- R10: `gp_code` is always 0. After reset, `gp_fault` and `acc_ok` are both 0. From the first clock edge after reset onward, `acc_ok` is the inverse of `gp_fault`.
- R11: With `REG_OUT`=1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_en | input | 1 | Protection enabled; when 0 the processor is in real mode |
| lma | input | 1 | Long mode active |
| cs_long | input | 1 | Current code segment runs in long mode |
| acc_addr | input | AW (32) | Access address, with the base already added |
| acc_size | input | SW (4) | Access size in bytes |
| acc_wr | input | 1 | Access is a write |
| acc_ex | input | 1 | Access is an instruction fetch |
| seg_base | input | AW (32) | Segment base |
| seg_limit | input | AW (32) | Segment limit |
| seg_rd | input | 1 | Segment is readable |
| seg_wr | input | 1 | Segment is writable |
| seg_down | input | 1 | Segment expands down |
| gp_fault | output | 1 | General-protection fault |
| acc_ok | output | 1 | Access passed all checks |
| gp_code | output | 16 | Fault error code, always zero |

## Verification
The assertions assume that the inputs stay constant over each clock period and that `acc_wr` and `acc_ex` are never both 1, since an access cannot be a write and a fetch at once. The bench changes every input only at the falling edge. It drives only combinations where at most one of the write and execute flags is set. It picks base, limit and address values near each inequality's boundary, one byte on either side, including an access that ends exactly at the top of the address space.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
    // Check path chosen for one access
    typedef enum logic [2:0] {
        P_OFF     = 3'd0,  // real mode or 64-bit code: no checks
        P_UP_FLAT = 3'd1,  // expand-up, limit >= base
        P_UP_WRAP = 3'd2,  // expand-up, limit < base
        P_DN_FLAT = 3'd3,  // expand-down, limit >= base
        P_DN_WRAP = 3'd4   // expand-down, limit < base
    } chk_path_e;

    // Output register state
    typedef enum logic {
        O_RESET = 1'b0,
        O_VALID = 1'b1
    } out_state_e;
endpackage

// File: rtl/seg_path_sel.sv
module seg_path_sel
    import seg_chk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          prot_en,
    input  logic          lma,
    input  logic          cs_long,
    input  logic          seg_down,
    input  logic [AW-1:0] seg_base,
    input  logic [AW-1:0] seg_limit,
    output chk_path_e     path
);
    logic skip;
    logic wraps;

    always_comb begin
        skip  = !prot_en || (lma && cs_long);
        wraps = seg_limit < seg_base;
        unique case ({skip, seg_down, wraps})
            3'b000:  path = P_UP_FLAT;
            3'b001:  path = P_UP_WRAP;
            3'b010:  path = P_DN_FLAT;
            3'b011:  path = P_DN_WRAP;
            default: path = P_OFF;
        endcase
    end
endmodule

// File: rtl/seg_attr_check.sv
module seg_attr_check
    import seg_chk_pkg::*;
(
    input  chk_path_e path,
    input  logic      acc_wr,
    input  logic      acc_ex,
    input  logic      seg_rd,
    input  logic      seg_wr,
    output logic      attr_fault
);
    logic wr_bad;
    logic rd_bad;

    always_comb begin
        wr_bad = acc_wr && !seg_wr;
        rd_bad = !acc_wr && !acc_ex && !seg_rd;
        unique case (path)
            P_OFF:   attr_fault = 1'b0;
            default: attr_fault = wr_bad || rd_bad;
        endcase
    end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_chk_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  chk_path_e     path,
    input  logic [AW-1:0] acc_addr,
    input  logic [SW-1:0] acc_size,
    input  logic [AW-1:0] seg_base,
    input  logic [AW-1:0] seg_limit,
    output logic          lim_fault
);
    localparam int EW = AW + 1;

    logic [EW-1:0] end_x;   // address + size, one bit wider
    logic [EW-1:0] lim_x;
    logic [EW-1:0] base_x;
    logic          end_past_lim;
    logic          addr_le_lim;
    logic          end_ge_base;
    logic          addr_lt_base;

    always_comb begin
        end_x  = {1'b0, acc_addr} + {{(EW-SW){1'b0}}, acc_size};
        lim_x  = {1'b0, seg_limit};
        base_x = {1'b0, seg_base};
        end_past_lim = lim_x < end_x;
        addr_le_lim  = acc_addr <= seg_limit;
        end_ge_base  = end_x >= base_x;
        addr_lt_base = acc_addr < seg_base;
        unique case (path)
            P_UP_FLAT: lim_fault = end_past_lim;
            P_UP_WRAP: lim_fault = end_past_lim && addr_lt_base;
            P_DN_FLAT: lim_fault = addr_le_lim && end_ge_base;
            P_DN_WRAP: lim_fault = addr_le_lim || end_ge_base;
            default:   lim_fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/seg_prot_checker.sv
module seg_prot_checker
    import seg_chk_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SW      = 4,
    parameter int CODE_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic              lma,
    input  logic              cs_long,
    input  logic [AW-1:0]     acc_addr,
    input  logic [SW-1:0]     acc_size,
    input  logic              acc_wr,
    input  logic              acc_ex,
    input  logic [AW-1:0]     seg_base,
    input  logic [AW-1:0]     seg_limit,
    input  logic              seg_rd,
    input  logic              seg_wr,
    input  logic              seg_down,
    output logic              gp_fault,
    output logic              acc_ok,
    output logic [CODE_W-1:0] gp_code
);
    chk_path_e path;
    logic      attr_fault;
    logic      lim_fault;
    logic      fault_next;

    seg_path_sel #(.AW(AW)) u_path (
        .prot_en  (prot_en),
        .lma      (lma),
        .cs_long  (cs_long),
        .seg_down (seg_down),
        .seg_base (seg_base),
        .seg_limit(seg_limit),
        .path     (path)
    );

    seg_attr_check u_attr (
        .path      (path),
        .acc_wr    (acc_wr),
        .acc_ex    (acc_ex),
        .seg_rd    (seg_rd),
        .seg_wr    (seg_wr),
        .attr_fault(attr_fault)
    );

    seg_limit_check #(.AW(AW), .SW(SW)) u_lim (
        .path     (path),
        .acc_addr (acc_addr),
        .acc_size (acc_size),
        .seg_base (seg_base),
        .seg_limit(seg_limit),
        .lim_fault(lim_fault)
    );

    assign fault_next = attr_fault || lim_fault;
    assign gp_code    = '0;

    generate
        if (REG_OUT) begin : g_reg
            out_state_e st_q;
            logic       fault_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q    <= O_RESET;
                    fault_q <= 1'b0;
                end else begin
                    st_q    <= O_VALID;
                    fault_q <= fault_next;
                end
            end

            always_comb begin
                unique case (st_q)
                    O_RESET: begin gp_fault = 1'b0;    acc_ok = 1'b0;     end
                    default: begin gp_fault = fault_q; acc_ok = !fault_q; end
                endcase
            end

            // R11: registered output follows the inputs of the prior edge
            a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> gp_fault == $past(fault_next));
            // R10: pass and fault are complementary once out of reset
            a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (acc_ok != gp_fault));
        end else begin : g_comb
            always_comb begin
                gp_fault = fault_next;
                acc_ok   = !fault_next;
            end
        end
    endgenerate

    // R1: real mode never faults
    a_r1_real_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> !fault_next);
    // R2: 64-bit code skips all checks
    a_r2_long_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (lma && cs_long) |-> (path == P_OFF) && !fault_next);
    // R3: writes to a read-only segment fault
    a_r3_write_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && !(lma && cs_long) && acc_wr && !seg_wr) |-> fault_next);
    // R4: plain reads of an unreadable segment fault
    a_r4_read_nr: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && !(lma && cs_long) && !acc_wr && !acc_ex && !seg_rd) |-> fault_next);
    // R5: expand-up access at or below the limit, ending in range, passes the limit check
    a_r5_up_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (path == P_UP_FLAT && acc_size == '0 && acc_addr <= seg_limit) |-> !lim_fault);
endmodule

// File: tb/sim_seg_prot_checker.sv
module sim_seg_prot_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_en = 1'b0, lma = 1'b0, cs_long = 1'b0;
    logic [31:0] acc_addr = '0, seg_base = '0, seg_limit = '0;
    logic [3:0]  acc_size = '0;
    logic        acc_wr = 1'b0, acc_ex = 1'b0;
    logic        seg_rd = 1'b1, seg_wr = 1'b1, seg_down = 1'b0;
    logic        gp_fault, acc_ok;
    logic [15:0] gp_code;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    seg_prot_checker u0 (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .lma(lma), .cs_long(cs_long),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wr(acc_wr), .acc_ex(acc_ex),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_rd(seg_rd), .seg_wr(seg_wr),
        .seg_down(seg_down), .gp_fault(gp_fault), .acc_ok(acc_ok), .gp_code(gp_code)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge, sample after the next rising edge.
    task automatic run(input string req,
                       input logic pe, input logic lm, input logic csl,
                       input logic dn, input logic rd, input logic wrs,
                       input logic [31:0] b, input logic [31:0] l,
                       input logic [31:0] a, input logic [3:0] sz,
                       input logic w, input logic x, input logic exp_fault);
        @(negedge clk);
        prot_en = pe; lma = lm; cs_long = csl;
        seg_down = dn; seg_rd = rd; seg_wr = wrs;
        seg_base = b; seg_limit = l; acc_addr = a; acc_size = sz;
        acc_wr = w; acc_ex = x;
        @(posedge clk);
        #1;
        check(req, gp_fault, exp_fault);
        check({req, " R10 pass"}, acc_ok, !exp_fault);
        check({req, " R10 code"}, gp_code == 16'h0, 1'b1);
    endtask

    task automatic t_reset;
        #1;
        check("R10 reset fault", gp_fault, 1'b0);
        check("R10 reset pass", acc_ok, 1'b0);
    endtask

    task automatic t_r1_real;
        run("R1 real oob", 0,0,0, 0,0,0, 32'h1000, 32'h1FFF, 32'h9000, 4, 1,0, 1'b0);
        run("R1 real read nr", 0,1,1, 1,0,0, 32'h8000, 32'h1000, 32'h0, 4, 0,0, 1'b0);
    endtask

    task automatic t_r2_long;
        run("R2 skip", 1,1,1, 0,0,0, 32'h1000, 32'h1FFF, 32'h9000, 4, 1,0, 1'b0);
        run("R2 lma only", 1,1,0, 0,1,0, 32'h0, 32'hFFFF_FFFF, 32'h10, 4, 1,0, 1'b1);
        run("R2 cs only", 1,0,1, 0,1,0, 32'h0, 32'hFFFF_FFFF, 32'h10, 4, 1,0, 1'b1);
    endtask

    task automatic t_r3_write;
        run("R3 write ro", 1,0,0, 0,1,0, 32'h0, 32'hFFFF, 32'h100, 4, 1,0, 1'b1);
        run("R3 write rw no read", 1,0,0, 0,0,1, 32'h0, 32'hFFFF, 32'h100, 4, 1,0, 1'b0);
    endtask

    task automatic t_r4_read;
        run("R4 read nr", 1,0,0, 0,0,1, 32'h0, 32'hFFFF, 32'h100, 4, 0,0, 1'b1);
        run("R4 exec nr", 1,0,0, 0,0,1, 32'h0, 32'hFFFF, 32'h100, 4, 0,1, 1'b0);
    endtask

    task automatic t_r5_up_flat;
        run("R5 end past", 1,0,0, 0,1,1, 32'h1000, 32'h1FFF, 32'h1FFC, 4, 0,0, 1'b1);
        run("R5 end at lim", 1,0,0, 0,1,1, 32'h1000, 32'h1FFF, 32'h1FFB, 4, 0,0, 1'b0);
    endtask

    task automatic t_r6_up_wrap;
        run("R6 end at lim", 1,0,0, 0,1,1, 32'h8000, 32'h1000, 32'h0FFC, 4, 0,0, 1'b0);
        run("R6 gap", 1,0,0, 0,1,1, 32'h8000, 32'h1000, 32'h1000, 4, 0,0, 1'b1);
        run("R6 above base", 1,0,0, 0,1,1, 32'h8000, 32'h1000, 32'h9000, 4, 0,0, 1'b0);
    endtask

    task automatic t_r7_dn_wrap;
        run("R7 at lim", 1,0,0, 1,1,1, 32'h8000, 32'h1000, 32'h1000, 4, 0,0, 1'b1);
        run("R7 inside", 1,0,0, 1,1,1, 32'h8000, 32'h1000, 32'h4000, 4, 0,0, 1'b0);
        run("R7 end at base", 1,0,0, 1,1,1, 32'h8000, 32'h1000, 32'h7FFC, 4, 0,0, 1'b1);
    endtask

    task automatic t_r8_dn_flat;
        run("R8 above lim", 1,0,0, 1,1,1, 32'h1000, 32'h8000, 32'h9000, 4, 0,0, 1'b0);
        run("R8 below base", 1,0,0, 1,1,1, 32'h1000, 32'h8000, 32'h0100, 4, 0,0, 1'b0);
        run("R8 hole", 1,0,0, 1,1,1, 32'h1000, 32'h8000, 32'h2000, 4, 0,0, 1'b1);
    endtask

    task automatic t_r9_carry;
        run("R9 top wrap", 1,0,0, 0,1,1, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 4, 0,0, 1'b1);
        run("R9 top fit", 1,0,0, 0,1,1, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 4, 0,0, 1'b0);
    endtask

    task automatic t_r11_latency;
        // fault-causing inputs applied; output must not change before the edge
        run("R11 setup", 1,0,0, 0,1,1, 32'h0, 32'hFFFF, 32'h100, 4, 0,0, 1'b0);
        @(negedge clk);
        seg_rd = 1'b0;
        #1;
        check("R11 before edge", gp_fault, 1'b0);
        @(posedge clk);
        #1;
        check("R11 after edge", gp_fault, 1'b1);
    endtask

    initial begin
        t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_r1_real();
        t_r2_long();
        t_r3_write();
        t_r4_read();
        t_r5_up_flat();
        t_r6_up_wrap();
        t_r7_dn_wrap();
        t_r8_dn_flat();
        t_r9_carry();
        t_r11_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule